// File: doc/BRIEF.md
# Multithreaded Reorder Buffer with Walking Squash

This block tracks in-flight operations for up to four hardware threads in one shared pool of entries. Each thread sees its own oldest-to-youngest chain. The chain is threaded through the pool by per-entry links, and each thread has its own head, tail and occupancy count. A front end inserts one operation per cycle, tagged with a thread number and a sequence number, and learns which pool slot it received. Execution units mark slots complete by index. A commit stage reads per-thread head readiness and retires the head of one thread per cycle.

Mis-speculation recovery is a squash request for one thread with a cut-off sequence number. Every entry of that thread with a larger number is discarded. The walk along the chain visits at most `SQUASH_WIDTH` entries per cycle and keeps its position between cycles. Victims are only flagged during the walk, so the thread's tail and count stay put. One cycle after the walk ends, the flagged slots are released at once, the tail snaps to the youngest survivor and the thread resumes. Partition limits are supplied from outside and only feed the per-thread free-space outputs. The block does not enforce them.

Top module: `rob_mt`

## Requirements
- R1: After reset every thread count, the total count and `can_commit` are 0. `rob_empty` is 1, `rob_full` is 0, every thread state is Idle, and every `sq_done` bit and `all_sq_done` are 1.
- R2: An insert to a thread that is not squashing writes the lowest-numbered free slot, reported combinationally on `ins_idx`. After the next edge the thread count has risen by one and the tail sequence equals the inserted number. An insert into an empty thread also makes it the head.
- R3: `head_ready[t]` is 1 exactly when thread t has entries, its head slot is marked complete and it is not squashing. Completing a non-head slot does not raise it. `can_commit` is the OR of `head_ready` over the threads whose `thr_active` bit is set.
- R4: A retire of a thread whose head is complete frees that slot. The head moves to the next entry in insertion order and the count drops by one.
- R5: A retire is ignored when the thread is empty or its head is not complete.
- R6: A squash removes every entry of the thread whose sequence number is greater than the cut-off. Older entries and other threads are untouched. Afterwards the tail is the youngest survivor, and the thread is Idle if nothing survived.
- R7: With n entries in the thread at the request, `sq_done[t]` goes low after the request edge. It is high again exactly ceil(n/SQUASH_WIDTH)+2 edges after the request edge, counting the request edge itself. Tail and count hold while the walk runs.
- R8: `thr_state` carries 2 bits per thread: Running=0, Idle=1, Squashing=2. Idle means an empty thread that is not squashing.
- R9: `all_sq_done` is 1 only when no thread is squashing.
- R10: `rob_full` is 1 when the total occupancy equals DEPTH and `rob_empty` is 1 when it is 0. `free_count` is DEPTH minus the occupancy. `thr_free[t]` is the thread limit minus its count, saturating at 0. An insert while no slot is free is dropped.
- R11: A squash request takes priority over a retire of the same thread in the same cycle. Inserts, retires and new squash requests for a thread that is squashing are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ins_valid | input | 1 | Insert request |
| ins_tid | input | TID_W | Thread of the insert |
| ins_seq | input | SEQ_W | Sequence number of the insert |
| ins_idx | output | IDX_W | Slot the insert takes (combinational) |
| cmp_valid | input | 1 | Completion mark |
| cmp_idx | input | IDX_W | Slot being marked complete |
| ret_valid | input | 1 | Retire request |
| ret_tid | input | TID_W | Thread whose head retires |
| sq_valid | input | 1 | Squash request |
| sq_tid | input | TID_W | Thread to squash |
| sq_seq | input | SEQ_W | Cut-off; larger numbers are discarded |
| thr_active | input | NT | Threads that take part in `can_commit` |
| thr_limit | input | NT*CNT_W | Per-thread entry limits, thread 0 in the low bits |
| head_ready | output | NT | Head of each thread is complete |
| can_commit | output | 1 | Some active thread has a ready head |
| thr_head_seq | output | NT*SEQ_W | Sequence number at each thread's head |
| thr_tail_seq | output | NT*SEQ_W | Sequence number at each thread's tail |
| thr_count | output | NT*CNT_W | Entries held per thread |
| thr_free | output | NT*CNT_W | Limit minus count, saturating |
| thr_state | output | NT*2 | Per-thread state code |
| sq_done | output | NT | Thread is not squashing |
| all_sq_done | output | 1 | No thread is squashing |
| total_count | output | CNT_W | Occupied slots |
| free_count | output | CNT_W | Unoccupied slots |
| rob_full | output | 1 | All slots occupied |
| rob_empty | output | 1 | No slot occupied |

## Verification
A broken link or a stale head pointer shows up on the next retire as a wrong `thr_head_seq`, one cycle after the edge. A walk that miscounts shows up as `sq_done` returning early or late, and as a tail or count that is wrong as soon as the squash finishes. Leaked or doubly owned slots appear as a mismatch between `total_count` and the summed thread counts, and as a wrong `ins_idx` on the first insert after a free. Full-pool and wholesale-squash cases make pool accounting errors visible at `rob_full` and `free_count`.

// File: rtl/rob_mt_pkg.sv
package rob_mt_pkg;

  typedef enum logic [1:0] {
    TS_RUN    = 2'd0,
    TS_IDLE   = 2'd1,
    TS_SQUASH = 2'd2
  } thr_state_e;

  // true when sequence a was issued after sequence b
  function automatic logic seq_younger(input int unsigned a, input int unsigned b);
    return a > b;
  endfunction

  // headroom left under a limit, never negative
  function automatic int unsigned sat_sub(input int unsigned lim, input int unsigned used);
    return (lim > used) ? lim - used : 0;
  endfunction

endpackage

// File: rtl/rob_alloc.sv
module rob_alloc #(
  parameter int DEPTH = 32,
  parameter int IDX_W = $clog2(DEPTH)
) (
  input  logic [DEPTH-1:0] busy,
  output logic             found,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int e = DEPTH - 1; e >= 0; e--) begin
      if (!busy[e]) begin
        found = 1'b1;
        idx   = IDX_W'(e);
      end
    end
  end
endmodule

// File: rtl/rob_walk.sv
module rob_walk #(
  parameter int DEPTH = 32,
  parameter int IDX_W = 5,
  parameter int SEQ_W = 16,
  parameter int CNT_W = 6,
  parameter int SW    = 2
) (
  input  logic [IDX_W-1:0]            ptr,
  input  logic [CNT_W-1:0]            remain,
  input  logic [SEQ_W-1:0]            cut_seq,
  input  logic [DEPTH-1:0][SEQ_W-1:0] seq_tab,
  input  logic [DEPTH-1:0][IDX_W-1:0] nxt_tab,
  output logic [DEPTH-1:0]            kill_vec,
  output logic [IDX_W-1:0]            ptr_o,
  output logic [CNT_W-1:0]            remain_o,
  output logic                        keep_hit,
  output logic [IDX_W-1:0]            keep_idx,
  output logic [CNT_W-1:0]            keep_add
);
  always_comb begin
    ptr_o    = ptr;
    remain_o = remain;
    kill_vec = '0;
    keep_hit = 1'b0;
    keep_idx = ptr;
    keep_add = '0;
    for (int k = 0; k < SW; k++) begin
      if (remain_o != '0) begin
        if (rob_mt_pkg::seq_younger(32'(seq_tab[ptr_o]), 32'(cut_seq))) begin
          kill_vec[ptr_o] = 1'b1;
        end else begin
          keep_hit = 1'b1;
          keep_idx = ptr_o;
          keep_add = keep_add + CNT_W'(1);
        end
        ptr_o    = nxt_tab[ptr_o];
        remain_o = remain_o - CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/rob_mt.sv
module rob_mt #(
  parameter int NT           = 4,
  parameter int DEPTH        = 32,
  parameter int SEQ_W        = 16,
  parameter int SQUASH_WIDTH = 2,
  parameter int TID_W        = $clog2(NT),
  parameter int IDX_W        = $clog2(DEPTH),
  parameter int CNT_W        = $clog2(DEPTH + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  ins_valid,
  input  logic [TID_W-1:0]      ins_tid,
  input  logic [SEQ_W-1:0]      ins_seq,
  output logic [IDX_W-1:0]      ins_idx,
  input  logic                  cmp_valid,
  input  logic [IDX_W-1:0]      cmp_idx,
  input  logic                  ret_valid,
  input  logic [TID_W-1:0]      ret_tid,
  input  logic                  sq_valid,
  input  logic [TID_W-1:0]      sq_tid,
  input  logic [SEQ_W-1:0]      sq_seq,
  input  logic [NT-1:0]         thr_active,
  input  logic [NT*CNT_W-1:0]   thr_limit,
  output logic [NT-1:0]         head_ready,
  output logic                  can_commit,
  output logic [NT*SEQ_W-1:0]   thr_head_seq,
  output logic [NT*SEQ_W-1:0]   thr_tail_seq,
  output logic [NT*CNT_W-1:0]   thr_count,
  output logic [NT*CNT_W-1:0]   thr_free,
  output logic [NT*2-1:0]       thr_state,
  output logic [NT-1:0]         sq_done,
  output logic                  all_sq_done,
  output logic [CNT_W-1:0]      total_count,
  output logic [CNT_W-1:0]      free_count,
  output logic                  rob_full,
  output logic                  rob_empty
);
  import rob_mt_pkg::*;

  // shared pool
  logic [DEPTH-1:0]            ent_v, ent_done, ent_sq;
  logic [DEPTH-1:0][TID_W-1:0] ent_tid;
  logic [DEPTH-1:0][SEQ_W-1:0] ent_seq;
  logic [DEPTH-1:0][IDX_W-1:0] ent_nxt;

  // per-thread list and walk state
  logic [IDX_W-1:0] hd [NT];
  logic [IDX_W-1:0] tl [NT];
  logic [CNT_W-1:0] cnt [NT];
  logic             sqing [NT];
  logic [SEQ_W-1:0] cut [NT];
  logic [IDX_W-1:0] wptr [NT];
  logic [CNT_W-1:0] wrem [NT];
  logic             surv [NT];
  logic [IDX_W-1:0] svidx [NT];
  logic [CNT_W-1:0] kept [NT];

  // walker results
  logic [DEPTH-1:0] w_kill [NT];
  logic [IDX_W-1:0] w_ptr  [NT];
  logic [CNT_W-1:0] w_rem  [NT];
  logic             w_hit  [NT];
  logic [IDX_W-1:0] w_kidx [NT];
  logic [CNT_W-1:0] w_kadd [NT];

  // named events
  logic             alloc_found;
  logic [IDX_W-1:0] alloc_idx;
  logic [NT-1:0]    ins_ev, ret_ev, sq_start, walk_ev, fin_ev, sq_hit;
  logic [CNT_W-1:0] occ_sum;

  rob_alloc #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_alloc (
    .busy(ent_v), .found(alloc_found), .idx(alloc_idx)
  );
  assign ins_idx = alloc_idx;

  genvar g;
  generate
    for (g = 0; g < NT; g++) begin : g_thr
      rob_walk #(.DEPTH(DEPTH), .IDX_W(IDX_W), .SEQ_W(SEQ_W), .CNT_W(CNT_W),
                 .SW(SQUASH_WIDTH)) u_walk (
        .ptr(wptr[g]), .remain(wrem[g]), .cut_seq(cut[g]),
        .seq_tab(ent_seq), .nxt_tab(ent_nxt),
        .kill_vec(w_kill[g]), .ptr_o(w_ptr[g]), .remain_o(w_rem[g]),
        .keep_hit(w_hit[g]), .keep_idx(w_kidx[g]), .keep_add(w_kadd[g])
      );

      assign sq_hit[g]   = sq_valid && (sq_tid == TID_W'(g));
      assign sq_start[g] = sq_hit[g] && !sqing[g];
      assign walk_ev[g]  = sqing[g] && (wrem[g] != '0);
      assign fin_ev[g]   = sqing[g] && (wrem[g] == '0);
      assign ins_ev[g]   = ins_valid && alloc_found && (ins_tid == TID_W'(g))
                           && !sqing[g] && !sq_hit[g];
      assign ret_ev[g]   = ret_valid && (ret_tid == TID_W'(g)) && (cnt[g] != '0)
                           && ent_done[hd[g]] && !sqing[g] && !sq_hit[g];

      assign head_ready[g] = (cnt[g] != '0) && ent_done[hd[g]] && !sqing[g];
      assign thr_head_seq[g*SEQ_W +: SEQ_W] = ent_seq[hd[g]];
      assign thr_tail_seq[g*SEQ_W +: SEQ_W] = ent_seq[tl[g]];
      assign thr_count[g*CNT_W +: CNT_W]    = cnt[g];
      assign thr_free[g*CNT_W +: CNT_W] =
        CNT_W'(sat_sub(32'(thr_limit[g*CNT_W +: CNT_W]), 32'(cnt[g])));
      assign thr_state[g*2 +: 2] = sqing[g]       ? TS_SQUASH :
                                   (cnt[g] == '0) ? TS_IDLE : TS_RUN;
      assign sq_done[g] = !sqing[g];

      // tail and count hold during a walk step
      p_tail_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        walk_ev[g] |=> $stable(tl[g]) && $stable(cnt[g]));
      // a squash request freezes the count of its thread for that edge
      p_sq_freeze_r11: assert property (@(posedge clk) disable iff (!rst_n)
        sq_start[g] |=> cnt[g] == $past(cnt[g]));
      // a ready head always sits in an occupied slot
      p_ready_valid_r3: assert property (@(posedge clk) disable iff (!rst_n)
        head_ready[g] |-> ent_v[hd[g]]);
      // a retired head slot is released
      p_retire_frees_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ret_ev[g] |=> !ent_v[$past(hd[g])]);
    end
  endgenerate

  assign can_commit  = |(head_ready & thr_active);
  assign all_sq_done = &sq_done;
  assign total_count = CNT_W'($countones(ent_v));
  assign free_count  = CNT_W'(DEPTH) - total_count;
  assign rob_full    = total_count == CNT_W'(DEPTH);
  assign rob_empty   = total_count == '0;

  always_comb begin
    occ_sum = '0;
    for (int t = 0; t < NT; t++) occ_sum = occ_sum + cnt[t];
  end

  // pool occupancy agrees with the per-thread counts
  p_count_sum_r10: assert property (@(posedge clk) disable iff (!rst_n)
    occ_sum == total_count);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ent_v    <= '0;
      ent_done <= '0;
      ent_sq   <= '0;
      ent_tid  <= '0;
      ent_seq  <= '0;
      ent_nxt  <= '0;
      for (int t = 0; t < NT; t++) begin
        hd[t] <= '0; tl[t] <= '0; cnt[t] <= '0; sqing[t] <= 1'b0;
        cut[t] <= '0; wptr[t] <= '0; wrem[t] <= '0; surv[t] <= 1'b0;
        svidx[t] <= '0; kept[t] <= '0;
      end
    end else begin
      if (cmp_valid) ent_done[cmp_idx] <= 1'b1;

      for (int t = 0; t < NT; t++) begin
        if (ret_ev[t]) begin
          ent_v[hd[t]]    <= 1'b0;
          ent_done[hd[t]] <= 1'b0;
          hd[t]           <= ent_nxt[hd[t]];
        end

        if (fin_ev[t]) cnt[t] <= kept[t];
        else cnt[t] <= cnt[t] + CNT_W'(ins_ev[t]) - CNT_W'(ret_ev[t]);

        if (ins_ev[t]) begin
          if ((cnt[t] == '0) || ((cnt[t] == CNT_W'(1)) && ret_ev[t])) hd[t] <= alloc_idx;
          else ent_nxt[tl[t]] <= alloc_idx;
          tl[t] <= alloc_idx;
        end

        if (sq_start[t]) begin
          sqing[t] <= 1'b1;
          cut[t]   <= sq_seq;
          wptr[t]  <= hd[t];
          wrem[t]  <= cnt[t];
          surv[t]  <= 1'b0;
          kept[t]  <= '0;
        end

        if (walk_ev[t]) begin
          for (int e = 0; e < DEPTH; e++) if (w_kill[t][e]) ent_sq[e] <= 1'b1;
          wptr[t] <= w_ptr[t];
          wrem[t] <= w_rem[t];
          kept[t] <= kept[t] + w_kadd[t];
          if (w_hit[t]) begin
            surv[t]  <= 1'b1;
            svidx[t] <= w_kidx[t];
          end
        end

        if (fin_ev[t]) begin
          for (int e = 0; e < DEPTH; e++) begin
            if (ent_v[e] && ent_sq[e] && (ent_tid[e] == TID_W'(t))) begin
              ent_v[e]    <= 1'b0;
              ent_sq[e]   <= 1'b0;
              ent_done[e] <= 1'b0;
            end
          end
          if (surv[t]) tl[t] <= svidx[t];
          sqing[t] <= 1'b0;
        end
      end

      if (|ins_ev) begin
        ent_v[alloc_idx]    <= 1'b1;
        ent_done[alloc_idx] <= 1'b0;
        ent_sq[alloc_idx]   <= 1'b0;
        ent_tid[alloc_idx]  <= ins_tid;
        ent_seq[alloc_idx]  <= ins_seq;
      end
    end
  end

endmodule

// File: tb/test_rob_mt.sv
`timescale 1ns/1ps
module test_rob_mt;
  localparam int NT = 4, DEPTH = 32, SEQ_W = 16, SW = 2;
  localparam int TID_W = 2, IDX_W = 5, CNT_W = 6;

  logic clk = 0, rst_n = 0;
  logic ins_valid = 0; logic [TID_W-1:0] ins_tid = 0; logic [SEQ_W-1:0] ins_seq = 0;
  logic [IDX_W-1:0] ins_idx;
  logic cmp_valid = 0; logic [IDX_W-1:0] cmp_idx = 0;
  logic ret_valid = 0; logic [TID_W-1:0] ret_tid = 0;
  logic sq_valid = 0; logic [TID_W-1:0] sq_tid = 0; logic [SEQ_W-1:0] sq_seq = 0;
  logic [NT-1:0] thr_active = 4'hF;
  logic [NT*CNT_W-1:0] thr_limit;
  logic [NT-1:0] head_ready, sq_done;
  logic can_commit, all_sq_done, rob_full, rob_empty;
  logic [NT*SEQ_W-1:0] thr_head_seq, thr_tail_seq;
  logic [NT*CNT_W-1:0] thr_count, thr_free;
  logic [NT*2-1:0] thr_state;
  logic [CNT_W-1:0] total_count, free_count;

  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  rob_mt i_rob_mt (.*);

  initial thr_limit = {6'd8, 6'd20, 6'd8, 6'd8};

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick(); @(negedge clk); endtask
  function automatic int cnt_of(input int t); return int'(thr_count[t*CNT_W +: CNT_W]); endfunction
  function automatic int hseq(input int t); return int'(thr_head_seq[t*SEQ_W +: SEQ_W]); endfunction
  function automatic int tseq(input int t); return int'(thr_tail_seq[t*SEQ_W +: SEQ_W]); endfunction
  function automatic int st_of(input int t); return int'(thr_state[t*2 +: 2]); endfunction

  task automatic insert(input int t, input int s, output int idx);
    ins_valid = 1; ins_tid = TID_W'(t); ins_seq = SEQ_W'(s);
    #1 idx = int'(ins_idx);
    tick(); ins_valid = 0;
  endtask
  task automatic complete(input int idx);
    cmp_valid = 1; cmp_idx = IDX_W'(idx); tick(); cmp_valid = 0;
  endtask
  task automatic retire(input int t);
    ret_valid = 1; ret_tid = TID_W'(t); tick(); ret_valid = 0;
  endtask
  // request a squash and return the extra edges until sq_done rises
  task automatic squash(input int t, input int s, output int n);
    sq_valid = 1; sq_tid = TID_W'(t); sq_seq = SEQ_W'(s); tick(); sq_valid = 0;
    chk("R7 sq_done low after request", int'(sq_done[t]), 0);
    chk("R8 state squashing", st_of(t), 2);
    chk("R9 all_sq_done low", int'(all_sq_done), 0);
    n = 0;
    while (!sq_done[t] && n < 40) begin tick(); n++; end
  endtask

  task automatic t_reset();
    chk("R1 total", int'(total_count), 0);
    chk("R1 empty", int'(rob_empty), 1);
    chk("R1 full", int'(rob_full), 0);
    chk("R1 can_commit", int'(can_commit), 0);
    chk("R9 all_sq_done", int'(all_sq_done), 1);
    for (int t = 0; t < NT; t++) begin
      chk("R1 count", cnt_of(t), 0);
      chk("R8 idle", st_of(t), 1);
    end
  endtask

  task automatic t_insert_retire();
    int i0, i1, i2, d;
    insert(0, 10, i0); insert(0, 11, i1); insert(0, 12, i2);
    chk("R2 idx first", i0, 0); chk("R2 idx third", i2, 2);
    chk("R2 count", cnt_of(0), 3);
    chk("R2 head", hseq(0), 10); chk("R2 tail", tseq(0), 12);
    chk("R8 running", st_of(0), 0);
    chk("R10 free_count", int'(free_count), 29);
    complete(i1);
    chk("R3 non-head completion", int'(head_ready[0]), 0);
    retire(0);
    chk("R5 retire incomplete head", cnt_of(0), 3);
    complete(i0);
    chk("R3 head ready", int'(head_ready[0]), 1);
    chk("R3 can_commit", int'(can_commit), 1);
    thr_active = 4'hE; #1;
    chk("R3 inactive thread masked", int'(can_commit), 0);
    thr_active = 4'hF;
    retire(0);
    chk("R4 count", cnt_of(0), 2); chk("R4 head advance", hseq(0), 11);
    chk("R3 next head ready", int'(head_ready[0]), 1);
    retire(0);
    chk("R4 head advance 2", hseq(0), 12);
    chk("R3 head not done", int'(head_ready[0]), 0);
    retire(1);
    chk("R5 retire empty thread", cnt_of(1), 0);
    chk("R5 other thread kept", cnt_of(0), 1);
    d = i2;
  endtask

  task automatic t_partial_squash();
    int ix, n;
    insert(1, 100, ix);
    chk("R2 reuse lowest freed slot", ix, 0);
    for (int s = 101; s <= 104; s++) insert(1, s, ix);
    chk("R2 count t1", cnt_of(1), 5);
    squash(1, 101, n);
    chk("R7 walk length", n, (5 + SW - 1) / SW + 1);
    chk("R6 survivors", cnt_of(1), 2);
    chk("R6 tail to survivor", tseq(1), 101);
    chk("R6 head kept", hseq(1), 100);
    chk("R6 other thread untouched", cnt_of(0), 1);
    chk("R8 running after", st_of(1), 0);
    chk("R9 all_sq_done back", int'(all_sq_done), 1);
    chk("R10 total", int'(total_count), 3);
  endtask

  task automatic t_priority();
    int ix;
    complete(2);
    chk("R3 t0 head ready", int'(head_ready[0]), 1);
    sq_valid = 1; sq_tid = 0; sq_seq = 12; ret_valid = 1; ret_tid = 0;
    tick(); sq_valid = 0; ret_valid = 0;
    chk("R3 no ready while squashing", int'(head_ready[0]), 0);
    chk("R7 tail held", tseq(0), 12);
    insert(0, 13, ix);
    tick();
    chk("R11 squash over retire, insert ignored", cnt_of(0), 1);
    chk("R11 tail unchanged", tseq(0), 12);
    chk("R7 done", int'(sq_done[0]), 1);
    retire(0);
    chk("R8 idle after retire", st_of(0), 1);
  endtask

  task automatic t_full_squash();
    int ix, n;
    squash(1, 50, n);
    chk("R7 walk length 2", n, (2 + SW - 1) / SW + 1);
    chk("R6 all removed", cnt_of(1), 0);
    chk("R6 idle", st_of(1), 1);
    insert(1, 60, ix);
    chk("R2 idx after free", ix, 0);
    chk("R2 head=tail", hseq(1), 60);
    for (int s = 200; s <= 230; s++) insert(2, s, ix);
    chk("R10 full", int'(rob_full), 1);
    chk("R10 free zero", int'(free_count), 0);
    chk("R10 thr_free saturates", int'(thr_free[2*CNT_W +: CNT_W]), 0);
    chk("R10 thr_free", int'(thr_free[1*CNT_W +: CNT_W]), 7);
    insert(3, 5, ix);
    chk("R10 insert dropped when full", cnt_of(3), 0);
    chk("R10 total stays", int'(total_count), 32);
    squash(2, 199, n);
    chk("R7 long walk", n, (31 + SW - 1) / SW + 1);
    chk("R6 t2 empty", cnt_of(2), 0);
    chk("R10 not full", int'(rob_full), 0);
    complete(0); retire(1);
    chk("R10 empty", int'(rob_empty), 1);
    chk("R10 free all", int'(free_count), 32);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) tick();
    rst_n = 1;
    tick();
    t_reset();
    t_insert_retire();
    t_partial_squash();
    t_priority();
    t_full_squash();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule